// File: doc/BRIEF.md
# High-Speed USB Transmit Serializer

This block sits between a link layer and the line driver of a high-speed USB transmitter. The link offers bytes on an 8-bit bus with a valid strobe, and the block acknowledges each byte it takes with a ready signal. Each packet goes out as a 32-bit sync field followed by the link's bytes, least significant bit first. The bit stream is bit-stuffed and NRZI-encoded, and an end-of-packet run closes the packet once the link drops its valid strobe. The block drives one serial line bit per clock together with an output-enable, so the whole block runs on the bit clock. Each byte handshake is a one-cycle ready pulse at a byte boundary.

When the block acts as a host and the packet is marked as a start-of-frame packet, the end-of-packet field is stretched to 40 bits. A strobe marks the 32nd of those bits. The disconnect comparator input is sampled on that strobe into a sticky flag, which holds until it is cleared or the block is reset.

Top module: `hs_tx_serializer`

## Requirements
- R1: While reset is held and after its release, line_out is 1, line_oe is 0, tx_ready is 0, disc_strobe is 0 and disc_flag is 0.
- R2: tx_valid seen high in idle starts a packet. line_oe is still 0 on the first cycle after that edge and is 1 on the second. The first 32 driven bits are 31 zeros and then a one, before encoding.
- R3: tx_ready goes high only in the cycle that decides the final sync bit or the final bit of the current byte, and only while tx_valid is high. A byte is taken on each edge where both are high. The byte present at start is the first one taken, on the 32nd cycle after the start edge.
- R4: If tx_valid is low at a byte boundary, the block moves to end-of-packet. From the moment the link drops tx_valid, tx_ready stays low until a new packet starts.
- R5: Bytes are sent bit 0 first. A zero is inserted before the next sync or data bit whenever the six bits before it were all ones, including runs that cross a byte boundary. No bit is inserted after a run of six ones that ends the data.
- R6: A 0 toggles line_out and a 1 holds it. When line_oe is 0, line_out is 1, so every packet starts encoding from 1.
- R7: End-of-packet is a run of ones with no stuffing. It is 8 bits long, or 40 bits when host_mode and sof_pkt were both high on the start edge. line_oe drops right after the last end-of-packet bit.
- R8: disc_strobe is high for exactly one cycle per 40-bit end-of-packet, the cycle in which the 32nd end-of-packet bit is on line_out. It never rises otherwise.
- R9: disc_flag rises on the edge after a disc_strobe cycle in which disc_in is high. It then stays high until disc_clear is seen high on an edge (clear wins) or reset.
- R10: With tx_valid raised again on the first idle cycle after an end-of-packet, line_oe is low for exactly two cycles between the two packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | Block acts as host; sampled at packet start |
| sof_pkt | input | 1 | Packet is a start-of-frame; sampled at packet start |
| tx_valid | input | 1 | Link has a byte on tx_data; low ends the packet |
| tx_data | input | 8 | Byte from the link; first byte is the packet ID |
| tx_ready | output | 1 | Byte on tx_data is taken at this edge when tx_valid is high |
| line_out | output | 1 | NRZI-encoded serial line bit |
| line_oe | output | 1 | Line driver enable |
| disc_in | input | 1 | Disconnect comparator output |
| disc_clear | input | 1 | Clears the sticky disconnect flag |
| disc_strobe | output | 1 | Marks the 32nd bit of a long end-of-packet |
| disc_flag | output | 1 | Sticky disconnect indication |

## Verification
Packets are built from byte patterns that each exercise a different path of the stuffing logic:
- Mixed bytes carry no long runs of ones.
- All-ones bytes force repeated stuffing inside a byte.
- Pairs of bytes split a six-one run across the byte boundary.
- A closing byte ends the data on exactly six ones, which must not be stuffed.

A scoreboard compares every driven line bit against an independent model of stuffing and NRZI encoding. The same comparison separates a missing stuff bit, a misplaced one and a wrong encoding polarity. Start-of-frame packets are sent with host mode on and off, and with disc_in high and low. This separates the long from the short end-of-packet, checks where the strobe lands, and confirms that the flag is set only when it should be. A back-to-back pair exercises the idle gap between packets.

// File: rtl/hs_tx_pkg.sv
`timescale 1ns/1ps
package hs_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_EOP
    } tx_state_e;
endpackage

// File: rtl/hs_tx_ctrl.sv
`timescale 1ns/1ps
// Packet sequencer: sync, byte shifting with stuffing, end-of-packet run.
module hs_tx_ctrl
    import hs_tx_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SYNC_BITS = 32,
    parameter int EOP_SHORT = 8,
    parameter int EOP_LONG  = 40,
    parameter int DISC_BIT  = 32,
    parameter int STUFF_RUN = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_mode,
    input  logic          sof_pkt,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    output logic          emit,
    output logic          tx_bit,
    output logic          disc_pick
);
    localparam int CNT_MAX = (SYNC_BITS > EOP_LONG) ? SYNC_BITS : EOP_LONG;
    localparam int CW = $clog2(CNT_MAX);
    localparam int IW = $clog2(DW);
    localparam int OW = $clog2(STUFF_RUN + 1);
    localparam logic [CW-1:0] SYNC_LAST  = CW'(SYNC_BITS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(EOP_SHORT - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(EOP_LONG - 1);
    localparam logic [CW-1:0] PICK_POS   = CW'(DISC_BIT - 1);
    localparam logic [IW-1:0] IDX_LAST   = IW'(DW - 1);
    localparam logic [OW-1:0] STUFF_LIM  = OW'(STUFF_RUN);

    typedef struct packed {
        tx_state_e     state;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] shreg;
        logic [OW-1:0] ones;
        logic          long_eop;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;
    logic [CW-1:0] eop_last;

    always_comb begin
        r_d       = r_q;
        emit      = 1'b0;
        tx_bit    = 1'b1;
        tx_ready  = 1'b0;
        disc_pick = 1'b0;
        eop_last  = r_q.long_eop ? LONG_LAST : SHORT_LAST;
        unique case (r_q.state)
            ST_IDLE: begin
                if (tx_valid) begin
                    r_d.state    = ST_SYNC;
                    r_d.cnt      = '0;
                    r_d.ones     = '0;
                    r_d.long_eop = host_mode & sof_pkt;
                end
            end
            ST_SYNC: begin
                emit     = 1'b1;
                tx_bit   = (r_q.cnt == SYNC_LAST);
                r_d.ones = tx_bit ? r_q.ones + OW'(1) : '0;
                if (r_q.cnt == SYNC_LAST) begin
                    tx_ready = tx_valid;
                    if (tx_valid) begin
                        r_d.shreg = tx_data;
                        r_d.idx   = '0;
                        r_d.state = ST_DATA;
                    end else begin
                        r_d.cnt   = '0;
                        r_d.state = ST_EOP;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_DATA: begin
                emit = 1'b1;
                if (r_q.ones == STUFF_LIM) begin
                    tx_bit   = 1'b0;
                    r_d.ones = '0;
                end else begin
                    tx_bit   = r_q.shreg[r_q.idx];
                    r_d.ones = tx_bit ? r_q.ones + OW'(1) : '0;
                    if (r_q.idx == IDX_LAST) begin
                        tx_ready = tx_valid;
                        if (tx_valid) begin
                            r_d.shreg = tx_data;
                            r_d.idx   = '0;
                        end else begin
                            r_d.cnt   = '0;
                            r_d.state = ST_EOP;
                        end
                    end else begin
                        r_d.idx = r_q.idx + IW'(1);
                    end
                end
            end
            ST_EOP: begin
                emit      = 1'b1;
                tx_bit    = 1'b1;
                disc_pick = r_q.long_eop && (r_q.cnt == PICK_POS);
                if (r_q.cnt == eop_last) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, idx: '0, shreg: '0, ones: '0, long_eop: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    AST_NO_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_EOP || r_q.state == ST_IDLE) |-> !tx_ready); // R4
    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ones <= STUFF_LIM); // R5
    AST_PICK_LONG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        disc_pick |-> (r_q.long_eop && r_q.state == ST_EOP)); // R8
endmodule

// File: rtl/hs_tx_nrzi.sv
`timescale 1ns/1ps
// NRZI line encoder with registered output enable.
module hs_tx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic emit,
    input  logic tx_bit,
    output logic line_out,
    output logic line_oe
);
    typedef struct packed {
        logic line;
        logic oe;
    } nrzi_regs_t;

    nrzi_regs_t n_q, n_d;

    always_comb begin
        n_d.oe   = emit;
        n_d.line = emit ? (tx_bit ? n_q.line : ~n_q.line) : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= '{line: 1'b1, oe: 1'b0};
        end else begin
            n_q <= n_d;
        end
    end

    assign line_out = n_q.line;
    assign line_oe  = n_q.oe;

    AST_HOLD_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && tx_bit) |=> (n_q.line == $past(n_q.line))); // R6
    AST_FLIP_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !tx_bit) |=> (n_q.line != $past(n_q.line))); // R6
    AST_IDLE_IS_J: assert property (@(posedge clk) disable iff (!rst_n)
        !n_q.oe |-> n_q.line); // R6
endmodule

// File: rtl/hs_tx_disc.sv
`timescale 1ns/1ps
// Disconnect sample strobe and sticky flag.
module hs_tx_disc (
    input  logic clk,
    input  logic rst_n,
    input  logic disc_pick,
    input  logic disc_in,
    input  logic disc_clear,
    output logic disc_strobe,
    output logic disc_flag
);
    typedef struct packed {
        logic strobe;
        logic flag;
    } disc_regs_t;

    disc_regs_t d_q, d_d;

    always_comb begin
        d_d.strobe = disc_pick;
        if (disc_clear) begin
            d_d.flag = 1'b0;
        end else begin
            d_d.flag = d_q.flag | (d_q.strobe & disc_in);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '{strobe: 1'b0, flag: 1'b0};
        end else begin
            d_q <= d_d;
        end
    end

    assign disc_strobe = d_q.strobe;
    assign disc_flag   = d_q.flag;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.flag && !disc_clear) |=> d_q.flag); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.strobe |=> !d_q.strobe); // R8
    AST_FLAG_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_q.flag && !(d_q.strobe && disc_in)) |=> !d_q.flag); // R9
endmodule

// File: rtl/hs_tx_serializer.sv
`timescale 1ns/1ps
// High-speed transmit serializer top.
module hs_tx_serializer #(
    parameter int DW        = 8,
    parameter int SYNC_BITS = 32,
    parameter int EOP_SHORT = 8,
    parameter int EOP_LONG  = 40,
    parameter int DISC_BIT  = 32,
    parameter int STUFF_RUN = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_mode,
    input  logic          sof_pkt,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    output logic          line_out,
    output logic          line_oe,
    input  logic          disc_in,
    input  logic          disc_clear,
    output logic          disc_strobe,
    output logic          disc_flag
);
    logic emit_w;
    logic bit_w;
    logic pick_w;

    hs_tx_ctrl #(
        .DW(DW), .SYNC_BITS(SYNC_BITS), .EOP_SHORT(EOP_SHORT),
        .EOP_LONG(EOP_LONG), .DISC_BIT(DISC_BIT), .STUFF_RUN(STUFF_RUN)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .sof_pkt(sof_pkt),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .emit(emit_w), .tx_bit(bit_w), .disc_pick(pick_w)
    );

    hs_tx_nrzi u_nrzi (
        .clk(clk), .rst_n(rst_n), .emit(emit_w), .tx_bit(bit_w),
        .line_out(line_out), .line_oe(line_oe)
    );

    hs_tx_disc u_disc (
        .clk(clk), .rst_n(rst_n), .disc_pick(pick_w), .disc_in(disc_in),
        .disc_clear(disc_clear), .disc_strobe(disc_strobe), .disc_flag(disc_flag)
    );
endmodule

// File: tb/hs_tx_serializer_test.sv
`timescale 1ns/1ps
module hs_tx_serializer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode = 1'b0;
    logic       sof_pkt = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready;
    logic       line_out;
    logic       line_oe;
    logic       disc_in = 1'b0;
    logic       disc_clear = 1'b0;
    logic       disc_strobe;
    logic       disc_flag;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    bit ended = 1'b0;
    logic nrzi_prev = 1'b1;
    logic [7:0] pk [0:15];

    logic exp_line [$];
    logic exp_strb [$];
    int   exp_req  [$];

    always #2.5 clk = ~clk;

    hs_tx_serializer uut (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .sof_pkt(sof_pkt),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .line_out(line_out), .line_oe(line_oe), .disc_in(disc_in),
        .disc_clear(disc_clear), .disc_strobe(disc_strobe), .disc_flag(disc_flag)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic push_bit(input logic raw, input logic strb, input int rq);
        logic ln;
        ln = raw ? nrzi_prev : ~nrzi_prev;
        nrzi_prev = ln;
        exp_line.push_back(ln);
        exp_strb.push_back(strb);
        exp_req.push_back(rq);
    endtask

    // Reference model: sync (R2), stuffing LSB first (R5), NRZI (R6), EOP (R7, R8)
    task automatic build_expect(input int n, input bit long_eop);
        int ones;
        int len;
        logic raw;
        nrzi_prev = 1'b1;
        ones = 0;
        for (int k = 0; k < 32; k++) begin
            raw = (k == 31);
            push_bit(raw, 1'b0, 2);
            ones = raw ? ones + 1 : 0;
        end
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (ones == 6) begin
                    push_bit(1'b0, 1'b0, 5);
                    ones = 0;
                end
                raw = pk[i][j];
                push_bit(raw, 1'b0, 5);
                ones = raw ? ones + 1 : 0;
            end
        end
        len = long_eop ? 40 : 8;
        for (int k = 0; k < len; k++) begin
            push_bit(1'b1, long_eop && (k == 31), 7);
        end
    endtask

    task automatic send_pkt(input int n, input logic host, input logic sof, input bit b2b);
        int idx;
        int cycles;
        if (!b2b) @(negedge clk);
        build_expect(n, host && sof);
        host_mode = host;
        sof_pkt   = sof;
        tx_data   = pk[0];
        tx_valid  = 1'b1;
        ended     = 1'b0;
        idx    = 0;
        cycles = 0;
        while (idx < n) begin
            @(negedge clk);
            cycles++;
            if (cycles == 1) check(!line_oe, b2b ? "R10" : "R2", "oe low one cycle after start", line_oe, 0);
            if (cycles == 2) check(line_oe, b2b ? "R10" : "R2", "oe high two cycles after start", line_oe, 1);
            if (tx_ready) begin
                if (idx == 0) check(cycles == 32, "R3", "cycle of first byte taken", cycles, 32);
                @(posedge clk);
                #1;
                idx++;
                if (idx < n) begin
                    tx_data = pk[idx];
                end else begin
                    tx_valid = 1'b0;
                    ended    = 1'b1;
                end
            end
        end
        @(negedge clk);
        while (line_oe) @(negedge clk);
        check(exp_line.size() == 0, "R7", "bits left unsent after oe fell", exp_line.size(), 0);
        exp_line.delete();
        exp_strb.delete();
        exp_req.delete();
    endtask

    // Monitor: pops the scoreboard as line bits appear
    always @(negedge clk) begin
        logic el;
        logic es;
        int   er;
        if (rst_n && !done) begin
            if (line_oe) begin
                if (exp_line.size() == 0) begin
                    check(1'b0, "R7", "driven bit beyond expected end", 1, 0);
                end else begin
                    el = exp_line.pop_front();
                    es = exp_strb.pop_front();
                    er = exp_req.pop_front();
                    check(line_out == el, $sformatf("R%0d", er), "line bit", line_out, el);
                    check(disc_strobe == es, "R8", "strobe on line bit", disc_strobe, es);
                end
            end else if (disc_strobe) begin
                check(1'b0, "R8", "strobe while not driving", 1, 0);
            end
            if (ended && tx_ready) check(1'b0, "R4", "ready after packet end", 1, 0);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(line_out == 1'b1, "R1", "line in reset", line_out, 1);
        check(line_oe == 1'b0, "R1", "oe in reset", line_oe, 0);
        check(tx_ready == 1'b0, "R1", "ready in reset", tx_ready, 0);
        check(disc_flag == 1'b0 && disc_strobe == 1'b0, "R1", "disc outputs in reset", disc_flag, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(line_out == 1'b1 && line_oe == 1'b0, "R1", "idle after reset", line_oe, 0);

        // Mixed bytes with one all-ones byte (R3, R5)
        pk[0] = 8'hA5; pk[1] = 8'h00; pk[2] = 8'hFF; pk[3] = 8'h3C;
        send_pkt(4, 1'b0, 1'b0, 1'b0);

        // Run straddling a byte boundary, trailing run of six ones unstuffed (R5)
        pk[0] = 8'h69; pk[1] = 8'hC0; pk[2] = 8'h0F; pk[3] = 8'hFC;
        send_pkt(4, 1'b0, 1'b0, 1'b0);

        // Repeated stuffing across several all-ones bytes (R5)
        pk[0] = 8'hE1; pk[1] = 8'hFF; pk[2] = 8'hFF; pk[3] = 8'hFF;
        send_pkt(4, 1'b1, 1'b0, 1'b0);

        // Host SOF with disconnect present: long EOP, strobe, flag set (R7, R8, R9)
        disc_in = 1'b1;
        pk[0] = 8'hA5; pk[1] = 8'h12; pk[2] = 8'h34;
        send_pkt(3, 1'b1, 1'b1, 1'b0);
        check(disc_flag == 1'b1, "R9", "flag after sampled disconnect", disc_flag, 1);
        repeat (4) @(negedge clk);
        check(disc_flag == 1'b1, "R9", "flag stays set", disc_flag, 1);
        disc_clear = 1'b1;
        @(negedge clk);
        disc_clear = 1'b0;
        check(disc_flag == 1'b0, "R9", "flag cleared", disc_flag, 0);

        // Device-mode SOF with disconnect high: short EOP, no strobe, flag stays low (R8)
        send_pkt(3, 1'b0, 1'b1, 1'b0);
        check(disc_flag == 1'b0, "R8", "no sample outside host SOF", disc_flag, 0);

        // Back-to-back packets (R10), second one host SOF with disconnect absent
        pk[0] = 8'hD2;
        send_pkt(1, 1'b1, 1'b0, 1'b0);
        disc_in = 1'b0;
        pk[0] = 8'hA5; pk[1] = 8'h7F; pk[2] = 8'h80;
        send_pkt(3, 1'b1, 1'b1, 1'b1);
        check(disc_flag == 1'b0, "R9", "flag low when disconnect absent", disc_flag, 0);
        check(tx_ready == 1'b0 && line_out == 1'b1, "R4", "idle after last packet", tx_ready, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog: run active 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule